// File: doc/BRIEF.md
# MDIO Management Master with Background PHY Scan

This block is a management-bus master for external Ethernet PHYs. It drives clause-22 management frames on a clock/data pair: a clock it divides down from the system clock, and a bidirectional data line split into an output, an output enable and an input. Software talks to it through a small word-wide register port with three registers. A control word sets the clock divider and the enable, and carries a drive-conflict fault flag with its own enable. A read-only presence bitmap has one bit per PHY address. A single command word holds the start flag, the direction, the PHY address, the register number and the 16-bit data.

Whenever no software command is waiting, the master reads a fixed status register at each of the 32 PHY addresses in turn. It records in the bitmap whether each address answered. Software can therefore see which PHYs are present without issuing any reads. A software command is served at the next frame boundary. While it runs, its start flag reads back as set, and further writes to the command word are dropped.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the control word (select 0) reads 0x8000_0000 | DIV_RST: bit 31 idle set, bit 30 enable clear, bit 17 fault clear, bit 16 fault-enable clear, bits 7:0 divider. The bitmap (select 1) and the command word (select 2) read zero, and mdc and mdio_oe are low.
- R2: When enabled, the mdc period is (divider + 1) system clocks. A divider of 0 behaves as 1. With enable clear, mdc is held low and no edges occur.
- R3: The command word is at select 2. Bit 31 is start, bit 30 is write (1) or read (0), bit 29 is acknowledge (read-only), bits 25:21 are the register number, bits 20:16 are the PHY address and bits 15:0 are the data. A write frame sends 32 ones, 01, opcode 01, the PHY address, the register number, 10 and then the data, every field MSB first. mdio_out changes only when mdc falls.
- R4: A read frame uses opcode 10 and releases mdio_oe from the first turnaround bit onward. At completion, bit 29 is set exactly when mdio_in was low at the second turnaround bit, and bits 15:0 hold the 16 bits sampled on the rising edges of mdc.
- R5: After a command word write with bit 31 set, bit 31 reads 1 until the frame ends and then clears. The control idle bit reads 0 while any frame is in progress.
- R6: A command word write while bit 31 is set has no effect on any field.
- R7: With no command waiting, the master reads register POLL_REG at PHY addresses in ascending order, wrapping from 31 to 0. Bitmap bit a (select 1) equals the acknowledge result of the latest scan of address a.
- R8: A waiting command starts no later than the frame after the one in progress when it was written.
- R9: With fault-enable (control bit 16) set, a sampled mdio_in that differs from mdio_out while the master drives sets control bit 17. Writing 1 to bit 17 clears it. With fault-enable clear, the flag never sets.
- R10: While enable is clear, no frame starts and a written command stays pending with bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 bitmap, 2 command |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | High while the master drives the data line |
| mdio_in | input | 1 | Sampled state of the data line |

## Verification
The bench builds the block with DIV_RST = 3, the default 32-bit preamble and POLL_REG = 1. It runs most traffic with the divider set to 1, so a frame lasts about 130 system clocks. This makes several full 32-address scans, a random mix of reads and writes to present and absent PHYs, and divider values 0, 1, 3 and 6 affordable in one run. The PHY model in the bench answers at three or more addresses and releases the line elsewhere, which exercises both acknowledge outcomes and the pull-up data of 0xFFFF.

// File: rtl/mdio_mgmt.sv
module mdio_mgmt #(
  parameter logic [7:0] DIV_RST  = 8'd31,
  parameter int         PRE_LEN  = 32,
  parameter logic [4:0] POLL_REG = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int FL = PRE_LEN + 32;
  localparam int BW = $clog2(FL + 1);
  localparam logic [BW-1:0] LAST = BW'(FL);
  localparam logic [BW-1:0] TA0  = BW'(PRE_LEN + 14);
  localparam logic [BW-1:0] TA1  = BW'(PRE_LEN + 15);
  localparam logic [BW-1:0] DAT0 = BW'(PRE_LEN + 16);

  logic [7:0]    div_q, cnt_q;
  logic          en_q, fen_q, flt_q;
  logic          go_q, wr_q, ack_q;
  logic [4:0]    ureg_q, uphy_q, ptr_q;
  logic [15:0]   udat_q, rsh_q;
  logic [31:0]   alive_q;
  logic          mdc_q, busy_q, cur_user_q, cur_rd_q, tack_q, mdo_q, oe_q;
  logic [BW-1:0] bit_q;
  logic [FL-1:0] sr_q, frm;

  logic [7:0] d, hd;
  logic       rise_ev, fall_ev;
  logic [BW-1:0] idx;
  logic unused_w;

  assign unused_w = ^reg_wdata[29:26];
  assign d        = (div_q == 8'd0) ? 8'd1 : div_q;
  assign hd       = (d - 8'd1) >> 1;
  assign rise_ev  = en_q && (cnt_q >= d);
  assign fall_ev  = en_q && mdc_q && (cnt_q >= hd) && (cnt_q < d);
  assign idx      = bit_q - BW'(1);

  assign mdc      = mdc_q;
  assign mdio_out = mdo_q;
  assign mdio_oe  = oe_q;

  always_comb begin
    if (go_q)
      frm = {{PRE_LEN{1'b1}}, 2'b01, (wr_q ? 2'b01 : 2'b10), uphy_q, ureg_q,
             2'b10, (wr_q ? udat_q : 16'hFFFF)};
    else
      frm = {{PRE_LEN{1'b1}}, 2'b01, 2'b10, ptr_q, POLL_REG, 2'b10, 16'hFFFF};
  end

  always_comb begin
    reg_rdata = 32'd0;
    case (reg_sel)
      2'd0: begin
        reg_rdata[31]  = !busy_q;
        reg_rdata[30]  = en_q;
        reg_rdata[17]  = flt_q;
        reg_rdata[16]  = fen_q;
        reg_rdata[7:0] = div_q;
      end
      2'd1: reg_rdata = alive_q;
      2'd2: reg_rdata = {go_q, wr_q, ack_q, 3'b000, ureg_q, uphy_q, udat_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 8'd0;
      mdc_q <= 1'b0;
    end else if (!en_q) begin
      cnt_q <= 8'd0;
      mdc_q <= 1'b0;
    end else if (rise_ev) begin
      cnt_q <= 8'd0;
      mdc_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 8'd1;
      if (fall_ev) mdc_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_RST;
      en_q  <= 1'b0;
      fen_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == 2'd0) begin
        div_q <= reg_wdata[7:0];
        en_q  <= reg_wdata[30];
        fen_q <= reg_wdata[16];
        if (reg_wdata[17]) flt_q <= 1'b0;
      end
      if (rise_ev && oe_q && fen_q && (mdio_in != mdo_q)) flt_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q       <= 1'b0;
      wr_q       <= 1'b0;
      ack_q      <= 1'b0;
      ureg_q     <= 5'd0;
      uphy_q     <= 5'd0;
      udat_q     <= 16'd0;
      alive_q    <= 32'd0;
      ptr_q      <= 5'd0;
      busy_q     <= 1'b0;
      cur_user_q <= 1'b0;
      cur_rd_q   <= 1'b0;
      tack_q     <= 1'b0;
      rsh_q      <= 16'd0;
      mdo_q      <= 1'b1;
      oe_q       <= 1'b0;
      bit_q      <= '0;
      sr_q       <= '0;
    end else begin
      if (reg_wr && reg_sel == 2'd2 && !go_q) begin
        go_q   <= reg_wdata[31];
        wr_q   <= reg_wdata[30];
        ack_q  <= 1'b0;
        ureg_q <= reg_wdata[25:21];
        uphy_q <= reg_wdata[20:16];
        udat_q <= reg_wdata[15:0];
      end

      if (rise_ev && busy_q && bit_q != '0 && cur_rd_q) begin
        if (idx == TA1) tack_q <= !mdio_in;
        if (idx >= DAT0) rsh_q <= {rsh_q[14:0], mdio_in};
      end

      if (fall_ev) begin
        if (busy_q && bit_q == LAST) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          mdo_q  <= 1'b1;
          if (cur_user_q) begin
            go_q  <= 1'b0;
            ack_q <= cur_rd_q && tack_q;
            if (cur_rd_q) udat_q <= rsh_q;
          end else begin
            alive_q[ptr_q] <= tack_q;
            ptr_q          <= ptr_q + 5'd1;
          end
        end else if (busy_q) begin
          mdo_q <= sr_q[FL-1];
          sr_q  <= {sr_q[FL-2:0], 1'b0};
          oe_q  <= !(cur_rd_q && bit_q >= TA0);
          bit_q <= bit_q + BW'(1);
        end else begin
          busy_q     <= 1'b1;
          cur_user_q <= go_q;
          cur_rd_q   <= go_q ? !wr_q : 1'b1;
          tack_q     <= 1'b0;
          mdo_q      <= frm[FL-1];
          sr_q       <= {frm[FL-2:0], 1'b0};
          oe_q       <= 1'b1;
          bit_q      <= BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        busy,
  input logic        go,
  input logic        cur_user,
  input logic [31:0] alive
);
  p_mdc_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

  p_mdo_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_out));

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  p_go_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> !busy);

  p_alive_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alive) |-> $past(busy && !cur_user));
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .mdc(mdc_q), .mdio_out(mdo_q),
  .mdio_oe(oe_q), .busy(busy_q), .go(go_q), .cur_user(cur_user_q),
  .alive(alive_q)
);

// File: tb/test_mdio_mgmt.sv
module test_mdio_mgmt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int total = 0, bad = 0, cyc = 0, mdc_rises = 0;
  logic        force_low, phy_oe, phy_val;
  logic [31:0] phy_map;
  logic [15:0] pmem [0:1023];
  int          m_idx = 0;
  logic [63:0] bits, frame_log;
  logic [4:0]  h_phy, h_reg;
  logic [1:0]  h_op;
  int          poll_hdr = 0, poll_at_user = 0, order_err = 0, last_poll = -1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mdio_in = force_low ? 1'b0 : mdio_oe ? mdio_out : phy_oe ? phy_val : 1'b1;

  mdio_mgmt #(.DIV_RST(8'd3), .PRE_LEN(32), .POLL_REG(5'd1)) i_mdio_mgmt (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

  // PHY model: captures master bits on rising mdc, answers reads on falling mdc
  always @(posedge mdc) begin
    mdc_rises++;
    if (m_idx == 64) m_idx = 0;
    if (mdio_oe) begin
      bits[63 - m_idx] = mdio_out;
      m_idx++;
      if (m_idx == 46) begin
        h_op  = bits[29:28];
        h_phy = bits[27:23];
        h_reg = bits[22:18];
        if (h_op == 2'b10 && h_reg == 5'd1) begin
          if (last_poll >= 0 && int'(h_phy) != ((last_poll + 1) % 32)) order_err++;
          last_poll = int'(h_phy);
          poll_hdr++;
        end else begin
          poll_at_user = poll_hdr;
        end
      end
      if (m_idx == 64 && h_op == 2'b01) begin
        frame_log = bits;
        if (phy_map[h_phy]) pmem[{h_phy, h_reg}] = bits[15:0];
      end
    end else if (m_idx >= 46 && m_idx < 64) begin
      m_idx++;
    end else begin
      m_idx = 0;
    end
  end

  always @(negedge mdc) begin
    if (m_idx >= 47 && m_idx <= 63 && h_op == 2'b10 && phy_map[h_phy]) begin
      phy_oe  = 1'b1;
      phy_val = (m_idx == 47) ? 1'b0 : pmem[{h_phy, h_reg}][63 - m_idx];
    end else begin
      phy_oe  = 1'b0;
      phy_val = 1'b1;
    end
  end

  function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] ph,
                                            input logic [4:0] rg, input logic [15:0] dt);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), ph, rg, 2'b10, dt};
  endfunction

  task automatic check(input logic ok, input string name, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", name, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] data);
    @(negedge clk);
    reg_sel = sel;
    #1 data = reg_rdata;
  endtask

  task automatic wait_go();
    logic [31:0] v;
    int t = 0;
    do begin rd(2, v); t++; end while (v[31] && t < 5000);
    check(!v[31], "R5 GO clears at frame end", 64'(v[31]), 64'd0);
  endtask

  task automatic per(input int exp, input string name);
    int t0, t1;
    @(posedge mdc); @(posedge mdc); t0 = cyc;
    @(posedge mdc); t1 = cyc;
    check(t1 - t0 == exp, name, 64'(t1 - t0), 64'(exp));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [4:0]  ph, rg;
    logic [15:0] dt;
    logic        w;
    int          p0, c, pw, s;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 32'd0;
    force_low = 1'b0; phy_oe = 1'b0; phy_val = 1'b1; phy_map = 32'd0;
    s = $urandom(32'h5eed);
    for (int k = 0; k < 1024; k++) pmem[k] = 16'($urandom);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd(0, v); check(v == 32'h8000_0003, "R1 control reset", 64'(v), 64'h8000_0003);
    rd(1, v); check(v == 32'd0, "R1 bitmap reset", 64'(v), 64'd0);
    rd(2, v); check(v == 32'd0, "R1 command reset", 64'(v), 64'd0);
    check(!mdc && !mdio_oe, "R1 pins low", 64'({mdc, mdio_oe}), 64'd0);

    phy_map = 32'h8002_0008;
    wr(2, {1'b1, 1'b0, 4'b0, 5'd2, 5'd3, 16'h0});
    repeat (300) @(negedge clk);
    check(mdc_rises == 0, "R10 no mdc while disabled", 64'(mdc_rises), 64'd0);
    rd(2, v); check(v[31], "R10 command pending", 64'(v[31]), 64'd1);
    p0 = poll_hdr;
    wr(0, 32'h4000_0001);
    wait_go();
    check(poll_at_user == p0, "R8 pending command goes first", 64'(poll_at_user - p0), 64'd0);
    rd(2, v);
    check(v[29], "R4 ack from present PHY", 64'(v[29]), 64'd1);
    check(v[15:0] == pmem[{5'd3, 5'd2}], "R4 read data", 64'(v[15:0]), 64'(pmem[{5'd3, 5'd2}]));

    per(2, "R2 period div=1");
    wr(0, 32'h4000_0000); per(2, "R2 period div=0 acts as 1");
    wr(0, 32'h4000_0006); per(7, "R2 period div=6");
    wr(0, 32'h4000_0003); per(4, "R2 period div=3");
    wr(0, 32'h0000_0001);
    repeat (3) @(negedge clk);
    check(!mdc, "R2 mdc low when disabled", 64'(mdc), 64'd0);
    c = mdc_rises;
    repeat (60) @(negedge clk);
    check(mdc_rises == c, "R2 no edges when disabled", 64'(mdc_rises - c), 64'd0);
    wr(0, 32'h4000_0001);

    for (int n = 0; n < 16; n++) begin
      case (n % 4)
        0: ph = 5'd3;
        1: ph = 5'd17;
        2: ph = 5'd31;
        default: ph = 5'($urandom);
      endcase
      rg = 5'($urandom); dt = 16'($urandom); w = 1'($urandom);
      wr(2, {1'b1, w, 4'b0, rg, ph, dt});
      rd(2, v); check(v[31], "R5 GO reads set", 64'(v[31]), 64'd1);
      wr(2, {1'b1, ~w, 4'b0, ~rg, ~ph, ~dt});
      rd(2, v);
      check(v[30] == w && v[25:0] == {rg, ph, dt}, "R6 write during GO ignored",
            64'({v[30], v[25:0]}), 64'({w, rg, ph, dt}));
      p0 = poll_hdr;
      if (n == 0) begin
        wait (mdio_oe);
        rd(0, v); check(!v[31], "R5 idle clear during frame", 64'(v[31]), 64'd0);
      end
      wait_go();
      check(poll_at_user - p0 <= 1, "R8 priority at frame boundary", 64'(poll_at_user - p0), 64'd1);
      if (w) begin
        check(frame_log == exp_frame(1'b1, ph, rg, dt), "R3 write frame bits",
              frame_log, exp_frame(1'b1, ph, rg, dt));
        if (phy_map[ph]) begin
          wr(2, {1'b1, 1'b0, 4'b0, rg, ph, 16'h0});
          wait_go();
          rd(2, v);
          check(v[29] && v[15:0] == dt, "R4 read back written data", 64'(v[29:0]), 64'({1'b1, 13'b0, rg, ph, dt}));
        end
      end else begin
        rd(2, v);
        check(v[29] == phy_map[ph], "R4 ack matches presence", 64'(v[29]), 64'(phy_map[ph]));
        check(v[15:0] == (phy_map[ph] ? pmem[{ph, rg}] : 16'hFFFF), "R4 read data",
              64'(v[15:0]), 64'(phy_map[ph] ? pmem[{ph, rg}] : 16'hFFFF));
      end
    end

    pw = poll_hdr;
    wait (poll_hdr >= pw + 34);
    repeat (200) @(negedge clk);
    rd(1, v); check(v == phy_map, "R7 bitmap after scan", 64'(v), 64'(phy_map));
    phy_map = $urandom | 32'h1;
    pw = poll_hdr;
    wait (poll_hdr >= pw + 34);
    repeat (200) @(negedge clk);
    rd(1, v); check(v == phy_map, "R7 bitmap follows change", 64'(v), 64'(phy_map));
    check(order_err == 0, "R7 ascending scan order", 64'(order_err), 64'd0);

    wr(0, 32'h4001_0001);
    wait (m_idx == 5);
    @(negedge clk); force_low = 1'b1;
    repeat (8) @(negedge clk); force_low = 1'b0;
    rd(0, v); check(v[17], "R9 fault set on conflict", 64'(v[17]), 64'd1);
    wr(0, 32'h4003_0001);
    rd(0, v); check(!v[17], "R9 fault cleared by write 1", 64'(v[17]), 64'd0);
    wr(0, 32'h4000_0001);
    wait (m_idx == 5);
    @(negedge clk); force_low = 1'b1;
    repeat (8) @(negedge clk); force_low = 1'b0;
    rd(0, v); check(!v[17], "R9 no fault when disabled", 64'(v[17]), 64'd0);

    summary();
    $finish;
  end
endmodule